// File: doc/BRIEF.md
# Serial Predictive Increment Controller

This block is the arithmetic core of a single-input single-output predictive controller whose control law has been reduced offline to one error gain and a set of gains on past control increments. When an intervention strobe arrives, it takes the current measured output, forms the error against a latched setpoint, and computes one new control increment. The increment is the error gain times the error minus a weighted sum of the 63 most recent increments. It adds that increment to the applied manipulated value and pushes it into its increment history. The law assumes the setpoint is held constant over the prediction horizon, so one scalar setpoint register is enough.

A host loads 64 signed Q8.8 gains through an index/value/write-strobe port and loads the setpoint through its own strobe. The host may hold the controller halted so that intervention strobes are dropped, or force one computation at once. One multiply-accumulate is done per cycle of the computation clock `clk`. The intervention strobe `tick` is a one-cycle pulse in that clock domain. A level `done` output tells the host that `u_out` and `du_out` hold fresh results.

Top module: `pred_inc_ctrl`

## Requirements
- R1: A cycle with `prm_wr` high stores the signed Q8.8 value `prm_val` in gain entry `prm_idx`. Entry 63 is the error gain Ke. Entry i-1 (0..62) is the gain Kiu_i on the increment from i steps back. All gains reset to 0.
- R2: A cycle with `sp_wr` high stores `sp_val` as the setpoint, which resets to 0.
- R3: An accepted start captures `y_meas`. The new increment is du = sat16(floor((Ke*(sp - y) - sum over i=1..63 of Kiu_i*du(k-i)) / 256)), and it appears on `du_out`.
- R4: `u_out` becomes sat16(previous `u_out` + du) at each completion. It resets to 0.
- R5: At each completion, du enters the newest history slot and the oldest slot is dropped. Between completions the history does not change.
- R6: `done` resets to 0. It is low from the edge that accepts a start, rises exactly 65 clock edges after that edge, and stays high until the next accepted start.
- R7: A `tick` while `halt` is high is ignored.
- R8: A `force_run` pulse while idle starts a computation even when `halt` is high.
- R9: A `tick` or `force_run` arriving while a computation is in progress has no effect.
- R10: `u_out` and `du_out` change only at the completion edge.
- R11: Both the increment and the applied value saturate to the range -32768..32767 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Computation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prm_idx | input | 6 | Gain entry index |
| prm_val | input | 16 | Gain value, signed Q8.8 |
| prm_wr | input | 1 | Gain write strobe |
| sp_val | input | 16 | Setpoint value, signed |
| sp_wr | input | 1 | Setpoint write strobe |
| y_meas | input | 16 | Measured process output, signed |
| tick | input | 1 | Intervention strobe, one cycle |
| halt | input | 1 | Drop intervention strobes while high |
| force_run | input | 1 | Start a computation at once if idle |
| u_out | output | 16 | Applied manipulated value, signed |
| du_out | output | 16 | Last control increment, signed |
| done | output | 1 | Results fresh, controller idle |

## Verification
A history slot holding the wrong value, or a gain stored at the wrong index, does not show at the next completion. It shows one or more interventions later, when that slot is weighted by a nonzero gain. For this reason the vector walk places nonzero gains on the first, second and last history positions and checks every completion against an independent model. A sequencer that miscounts shows at once as a `done` latency other than 65 edges. A strobe that should have been dropped but was accepted shows as a change of `u_out`, or as a wrong result at the next intervention once the history has moved.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } pic_state_e;
endpackage

// File: rtl/pic_gain_bank.sv
module pic_gain_bank #(
   parameter int NG   = 64,
   parameter int DW   = 16,
   parameter int IDXW = $clog2(NG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [IDXW-1:0]      wr_idx,
   input  logic signed [DW-1:0] wr_val,
   input  logic [IDXW-1:0]      rd_idx,
   output logic signed [DW-1:0] rd_val
);
   logic signed [DW-1:0] mem [NG];

   for (genvar g = 0; g < NG; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr && (int'(wr_idx) == g))
            mem[g] <= wr_val;
      end
   end

   always_comb begin
      rd_val = '0;
      if (int'(rd_idx) < NG)
         rd_val = mem[rd_idx];
   end
endmodule

// File: rtl/pic_hist_shift.sv
module pic_hist_shift #(
   parameter int DEPTH = 63,
   parameter int DW    = 16,
   parameter int HW    = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift,
   input  logic signed [DW-1:0] din,
   input  logic [HW-1:0]        rd_idx,
   output logic signed [DW-1:0] rd_val
);
   logic signed [DW-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     slot[g] <= '0;
            else if (shift) slot[g] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     slot[g] <= '0;
            else if (shift) slot[g] <= slot[g-1];
         end
      end
   end

   always_comb begin
      rd_val = '0;
      if (int'(rd_idx) < DEPTH)
         rd_val = slot[rd_idx];
   end
endmodule

// File: rtl/pic_mac.sv
module pic_mac #(
   parameter int DW         = 16,
   parameter int FRAC       = 8,
   parameter int ACCW       = 40,
   parameter bit ROUND_NEAR = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 first,
   input  logic signed [DW-1:0] gain,
   input  logic signed [DW:0]   opnd,
   output logic signed [DW-1:0] du_sat
);
   localparam int PW = 2 * DW + 1;
   localparam logic signed [ACCW-1:0] HALF = ACCW'(1) << (FRAC - 1);

   logic signed [PW-1:0]   prod;
   logic signed [ACCW-1:0] prod_x;
   logic signed [ACCW-1:0] acc;
   logic signed [ACCW-1:0] scaled;
   logic [ACCW-DW:0]       top;

   assign prod   = gain * opnd;
   assign prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (en)    acc <= first ? prod_x : (acc - prod_x);
   end

   if (ROUND_NEAR) begin : g_round
      assign scaled = (acc + HALF) >>> FRAC;
   end else begin : g_floor
      assign scaled = acc >>> FRAC;
   end

   assign top = scaled[ACCW-1:DW-1];

   always_comb begin
      if ((&top) || !(|top))
         du_sat = scaled[DW-1:0];
      else if (scaled[ACCW-1])
         du_sat = {1'b1, {(DW-1){1'b0}}};
      else
         du_sat = {1'b0, {(DW-1){1'b1}}};
   end
endmodule

// File: rtl/pred_inc_ctrl.sv
module pred_inc_ctrl #(
   parameter int DW         = 16,
   parameter int NPAST      = 63,
   parameter int FRAC       = 8,
   parameter int ACCW       = 40,
   parameter bit ROUND_NEAR = 1'b0,
   localparam int NG        = NPAST + 1,
   localparam int IDXW      = $clog2(NG),
   localparam int HW        = (NPAST > 1) ? $clog2(NPAST) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] prm_idx,
   input  logic [DW-1:0]   prm_val,
   input  logic            prm_wr,
   input  logic [DW-1:0]   sp_val,
   input  logic            sp_wr,
   input  logic [DW-1:0]   y_meas,
   input  logic            tick,
   input  logic            halt,
   input  logic            force_run,
   output logic [DW-1:0]   u_out,
   output logic [DW-1:0]   du_out,
   output logic            done
);
   import pic_pkg::*;

   initial begin
      if (DW < 4)                  $error("DW too small");
      if (FRAC < 1 || FRAC >= DW)  $error("FRAC out of range");
      if (NPAST < 1)               $error("NPAST must be positive");
      if (ACCW < 2 * DW + 1 + IDXW) $error("ACCW too narrow");
   end

   pic_state_e           state;
   logic [IDXW-1:0]      cnt;
   logic signed [DW-1:0] sp_q;
   logic signed [DW:0]   err_q;
   logic signed [DW-1:0] u_q;
   logic signed [DW-1:0] du_q;
   logic                 done_q;

   logic                 busy, fin, go;
   logic [IDXW-1:0]      g_idx;
   logic [HW-1:0]        h_idx;
   logic signed [DW-1:0] g_val, h_val, du_new;
   logic signed [DW:0]   opnd;
   logic signed [DW:0]   u_sum;
   logic signed [DW-1:0] u_new;

   assign busy = (state != ST_IDLE);
   assign fin  = (state == ST_FIN);
   assign go   = (state == ST_IDLE) && ((tick && !halt) || force_run);

   assign g_idx = (cnt == '0) ? IDXW'(NG - 1) : (cnt - 1'b1);
   assign h_idx = HW'(cnt - 1'b1);
   assign opnd  = (cnt == '0) ? err_q : {h_val[DW-1], h_val};

   pic_gain_bank #(.NG(NG), .DW(DW), .IDXW(IDXW)) u_gain (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (prm_wr),
      .wr_idx (prm_idx),
      .wr_val (prm_val),
      .rd_idx (g_idx),
      .rd_val (g_val)
   );

   pic_hist_shift #(.DEPTH(NPAST), .DW(DW), .HW(HW)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (fin),
      .din    (du_new),
      .rd_idx (h_idx),
      .rd_val (h_val)
   );

   pic_mac #(.DW(DW), .FRAC(FRAC), .ACCW(ACCW), .ROUND_NEAR(ROUND_NEAR)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (state == ST_RUN),
      .first  (cnt == '0),
      .gain   (g_val),
      .opnd   (opnd),
      .du_sat (du_new)
   );

   assign u_sum = {u_q[DW-1], u_q} + {du_new[DW-1], du_new};

   always_comb begin
      if (u_sum[DW] == u_sum[DW-1])
         u_new = u_sum[DW-1:0];
      else if (u_sum[DW])
         u_new = {1'b1, {(DW-1){1'b0}}};
      else
         u_new = {1'b0, {(DW-1){1'b1}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sp_q <= '0;
      else if (sp_wr) sp_q <= sp_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         err_q  <= '0;
         u_q    <= '0;
         du_q   <= '0;
         done_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (go) begin
                  err_q  <= {sp_q[DW-1], sp_q} - {y_meas[DW-1], y_meas};
                  cnt    <= '0;
                  done_q <= 1'b0;
                  state  <= ST_RUN;
               end
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == IDXW'(NG - 1))
                  state <= ST_FIN;
            end
            ST_FIN: begin
               u_q    <= u_new;
               du_q   <= du_new;
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign u_out  = u_q;
   assign du_out = du_q;
   assign done   = done_q;
endmodule

// File: rtl/pred_inc_ctrl_chk.sv
module pred_inc_ctrl_chk #(
   parameter int DW    = 16,
   parameter int NPAST = 63
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          halt,
   input logic          force_run,
   input logic          done,
   input logic [DW-1:0] u_out,
   input logic [DW-1:0] du_out,
   input logic          busy,
   input logic          fin,
   input logic          go
);
   localparam int LAT = NPAST + 3;
   logic [15:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lat_cnt <= '0;
      else if (go)   lat_cnt <= 16'd1;
      else if (busy) lat_cnt <= lat_cnt + 16'd1;
   end

   AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);                                                    // R6
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (lat_cnt == 16'(LAT)));                            // R6
   AST_HALT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tick && halt && !force_run) |=> !busy);                  // R7
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin && (tick || force_run)) |=> (lat_cnt == $past(lat_cnt) + 16'd1)); // R9
   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> ($stable(u_out) && $stable(du_out)));                     // R10
endmodule

bind pred_inc_ctrl pred_inc_ctrl_chk #(.DW(DW), .NPAST(NPAST)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .halt      (halt),
   .force_run (force_run),
   .done      (done),
   .u_out     (u_out),
   .du_out    (du_out),
   .busy      (busy),
   .fin       (fin),
   .go        (go)
);

// File: tb/pred_inc_ctrl_bench.sv
`timescale 1ns/1ps
module pred_inc_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  prm_idx = '0;
   logic [15:0] prm_val = '0;
   logic        prm_wr = 1'b0;
   logic [15:0] sp_val = '0;
   logic        sp_wr = 1'b0;
   logic [15:0] y_meas = '0;
   logic        tick = 1'b0;
   logic        halt = 1'b0;
   logic        force_run = 1'b0;
   logic [15:0] u_out, du_out;
   logic        done;

   int total = 0;
   int bad = 0;

   // independent model
   int gm [64];
   int hm [63];
   int sp_m = 0;
   int u_m = 0;
   int du_m = 0;

   // stimulus table: {setpoint, measured output}
   localparam int NV = 7;
   localparam int VEC [NV][2] = '{
      '{1000, 0}, '{1000, 200}, '{1000, 900}, '{1000, 1000},
      '{1000, 1500}, '{-500, -3000}, '{0, 700}
   };

   always #2.5 clk = ~clk;

   pred_inc_ctrl u_pred_inc_ctrl (
      .clk(clk), .rst_n(rst_n), .prm_idx(prm_idx), .prm_val(prm_val),
      .prm_wr(prm_wr), .sp_val(sp_val), .sp_wr(sp_wr), .y_meas(y_meas),
      .tick(tick), .halt(halt), .force_run(force_run),
      .u_out(u_out), .du_out(du_out), .done(done)
   );

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int sat16(input longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   function automatic void model_step(input int y);
      longint acc;
      acc = longint'(gm[63]) * longint'(sp_m - y);
      for (int i = 0; i < 63; i++)
         acc = acc - longint'(gm[i]) * longint'(hm[i]);
      du_m = sat16(acc >>> 8);
      u_m  = sat16(longint'(u_m) + longint'(du_m));
      for (int i = 62; i > 0; i--) hm[i] = hm[i-1];
      hm[0] = du_m;
   endfunction

   task automatic wr_gain(input int idx, input int val);
      @(negedge clk);
      prm_idx = 6'(idx); prm_val = 16'(val); prm_wr = 1'b1;
      @(negedge clk);
      prm_wr = 1'b0;
      gm[idx] = val;
   endtask

   task automatic wr_sp(input int val);
      @(negedge clk);
      sp_val = 16'(val); sp_wr = 1'b1;
      @(negedge clk);
      sp_wr = 1'b0;
      sp_m = val;
   endtask

   // start with tick (use_force=0) or force_run (use_force=1); return edges to done
   task automatic run_op(input int y, input bit use_force, output int lat);
      @(negedge clk);
      y_meas = 16'(y);
      if (use_force) force_run = 1'b1; else tick = 1'b1;
      @(posedge clk);
      #1;
      tick = 1'b0; force_run = 1'b0;
      chk("R6 done cleared on accept", int'(done), 0);
      lat = 0;
      while (!done && lat < 200) begin
         @(posedge clk);
         lat++;
         #1;
      end
   endtask

   task automatic chk_outs(input string tag);
      chk({tag, " du"}, int'($signed(du_out)), du_m);
      chk({tag, " u"},  int'($signed(u_out)),  u_m);
   endtask

   initial begin
      #(5.0 * 200000);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lat;
      int u_hold;
      for (int i = 0; i < 64; i++) gm[i] = 0;
      for (int i = 0; i < 63; i++) hm[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R4 reset u", int'(u_out), 0);
      chk("R3 reset du", int'(du_out), 0);
      chk("R6 reset done", int'(done), 0);

      // R1: Ke=2.0, Kiu_1=0.5, Kiu_2=-0.25, Kiu_63=0.125
      wr_gain(63, 512);
      wr_gain(0, 128);
      wr_gain(1, -64);
      wr_gain(62, 32);

      // table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         if (VEC[v][0] != sp_m) wr_sp(VEC[v][0]);
         run_op(VEC[v][1], 1'b0, lat);
         model_step(VEC[v][1]);
         chk("R6 latency", lat, 65);
         chk_outs($sformatf("R3 R4 R5 vec%0d", v));
      end

      // R7: tick while halted is ignored
      halt = 1'b1;
      u_hold = int'($signed(u_out));
      @(negedge clk); y_meas = 16'(-2000); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (80) @(negedge clk);
      chk("R7 halted tick keeps u", int'($signed(u_out)), u_hold);
      chk("R7 halted tick keeps done", int'(done), 1);

      // R8: force runs while halted; R5 history untouched by the dropped tick
      run_op(-2000, 1'b1, lat);
      model_step(-2000);
      chk("R8 force latency", lat, 65);
      chk_outs("R8 R5 forced");
      halt = 1'b0;

      // R9: force while busy has no effect
      run_op(300, 1'b0, lat);
      model_step(300);
      chk_outs("R9 pre");
      @(negedge clk); y_meas = 16'(300); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (10) @(negedge clk);
      force_run = 1'b1;
      @(negedge clk); force_run = 1'b0;
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      while (!done) @(negedge clk);
      model_step(300);
      chk_outs("R9 single run");
      repeat (80) @(negedge clk);
      chk_outs("R9 no second run");
      chk("R10 outputs held idle", int'(done), 1);

      // R11: saturation high then low
      wr_gain(63, 32767);
      wr_sp(32767);
      run_op(-32768, 1'b0, lat);
      model_step(-32768);
      chk("R11 du clamps high", int'($signed(du_out)), 32767);
      chk("R11 u clamps high", int'($signed(u_out)), 32767);
      wr_sp(-32768);
      run_op(32767, 1'b0, lat);
      model_step(32767);
      chk("R11 du clamps low", int'($signed(du_out)), -32768);
      chk_outs("R11 low");
      run_op(32767, 1'b0, lat);
      model_step(32767);
      chk("R11 u clamps low", int'($signed(u_out)), -32768);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule